// File: doc/BRIEF.md
# Survivor-Memory Traceback Address Unit

This block walks a decoder's survivor memory backward from a chosen starting trellis position and produces the decoded bits of one traceback run. The survivor memory is external. Each of its 4096 words is 8 bits wide, and it returns data one cycle after a read strobe. The block supports constraint lengths 7 to 10. The caller supplies the best state and the iteration from which to begin. The state is given as a column field and a row field: the row selects a bit inside a memory word, and the column together with the iteration forms the word address.

Each backward step takes two clock cycles. In the first cycle the block issues the read. In the second cycle it picks the survivor bit out of the returned word and derives the previous position using two XOR gates and a field split that depends on the constraint length. The iteration count goes down by one on every step. The steps before the traceback depth only move the position back. The steps from the depth onward produce decoded bits, which collect in a small last-in-first-out store. When the run ends, that store is emptied one bit per cycle in chronological order, and each bit comes with a valid strobe.

Top module: `tbu_top`

## Requirements
- R1: When `start` is sampled high while the block is idle, `busy` rises and `mem_rd` is high in the following cycle. The first `mem_addr` is the column field (its low `3+k_sel` bits) in the low bits, with the iteration value above it. `k_sel` values 0,1,2,3 select constraint length 7,8,9,10.
- R2: Every step takes two cycles: a cycle with `mem_rd` high, then a cycle with it low. The survivor bit is bit `row` of the `mem_data` word returned for that read, where `row` is the current 3-bit row field.
- R3: Let W be the column width. With row bits r2 r1 r0, the top column bit hi = col[W-1], the next bit nx = col[W-2], and survivor bit v, the next row is {r1^nx, v, hi}. The next column is {col[W-2:0], r2^hi}. For example, K=7, row 101, column 100, v=1 gives row 011 and column 000.
- R4: The iteration field occupies the top `9-k_sel` address bits. It drops by one on each step and wraps from 0 to all ones.
- R5: One run performs TB+N-1 steps, where N = 16 >> k_sel (16, 8, 4 or 2) and TB is the effective depth. The run is therefore busy for 2(TB+N-1) cycles before output begins.
- R6: The survivor bits of steps TB to TB+N-1 (counting the first step as 1) are the decoded bits. After the last step they appear on `dec_bit` with `dec_valid` high for N consecutive cycles, last-read first. `busy` falls with the final bit.
- R7: The effective depth is `tb_depth` clamped to at least 1. It is also clamped to at most 49, 57, 61 or 62 for K = 7, 8, 9 or 10.
- R8: `start` has no effect while `busy` is high.
- R9: After reset, `busy`, `mem_rd` and `dec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| k_sel | input | 2 | Constraint length minus 7 |
| tb_depth | input | 6 | Requested traceback depth |
| start_iter | input | 9 | Starting iteration count |
| start_col | input | 6 | Starting column field of the best state |
| start_row | input | 3 | Starting row (bit index) of the best state |
| mem_rd | output | 1 | Survivor memory read strobe |
| mem_addr | output | 12 | Survivor memory word address |
| mem_data | input | 8 | Word returned one cycle after the strobe |
| busy | output | 1 | Run in progress |
| dec_valid | output | 1 | Decoded bit valid |
| dec_bit | output | 1 | Decoded bit, oldest first |

## Verification
The bench sets up the stated K=7 example in memory and confirms that the next read lands on column 000 one iteration back. A swapped XOR tap or misplaced survivor bit would send every later read to the wrong word. It starts a K=10 run at iteration 0, so a decrement that fails to wrap inside the 6-bit field would leave the address range the run should use. Depths 0 and 63 are applied to expose a missing clamp, which would show up as a wrong run length. A start pulse in the middle of a run checks that parameters cannot be reloaded while busy. Output order is compared bit by bit, so a store that emitted bits first-in-first-out would return them reversed.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
   typedef enum logic [1:0] {
      TB_IDLE  = 2'd0,
      TB_READ  = 2'd1,
      TB_EVAL  = 2'd2,
      TB_DRAIN = 2'd3
   } tbu_state_e;
endpackage

// File: rtl/tbu_addr.sv
module tbu_addr #(
   parameter int ADDR_W  = 12,
   parameter int ITER_W  = 9,
   parameter int COL_W   = 6,
   parameter int COL_MIN = 3,
   parameter int K_NUM   = 4
) (
   input  logic [1:0]        ksel,
   input  logic [ITER_W-1:0] iter,
   input  logic [COL_W-1:0]  col,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] cand [K_NUM];

   if (ITER_W + COL_MIN != ADDR_W) begin : g_bad_split
      $error("iteration and column widths must fill the address");
   end

   for (genvar kk = 0; kk < K_NUM; kk++) begin : g_split
      localparam int CW = COL_MIN + kk;
      assign cand[kk] = {iter[ITER_W-1-kk:0], col[CW-1:0]};
   end

   assign addr = cand[ksel];
endmodule

// File: rtl/tbu_prev.sv
module tbu_prev #(
   parameter int COL_W   = 6,
   parameter int COL_MIN = 3,
   parameter int K_NUM   = 4
) (
   input  logic [1:0]       ksel,
   input  logic [2:1]       row_hi,
   input  logic [COL_W-1:0] col,
   input  logic             v,
   output logic [2:0]       prev_row,
   output logic [COL_W-1:0] prev_col
);
   logic [2:0]       prow_c [K_NUM];
   logic [COL_W-1:0] pcol_c [K_NUM];

   if (COL_MIN < 2) begin : g_bad_col
      $error("column field needs at least two bits");
   end

   for (genvar kk = 0; kk < K_NUM; kk++) begin : g_step
      localparam int CW = COL_MIN + kk;
      logic hi, nx;
      assign hi = col[CW-1];
      assign nx = col[CW-2];
      assign prow_c[kk] = {row_hi[1] ^ nx, v, hi};
      if (CW < COL_W) begin : g_pad
         assign pcol_c[kk] = {{(COL_W-CW){1'b0}}, col[CW-2:0], row_hi[2] ^ hi};
      end else begin : g_full
         assign pcol_c[kk] = {col[CW-2:0], row_hi[2] ^ hi};
      end
   end

   assign prev_row = prow_c[ksel];
   assign prev_col = pcol_c[ksel];
endmodule

// File: rtl/tbu_lifo.sv
module tbu_lifo #(
   parameter int N = 16,
   localparam int LW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          din,
   input  logic          pop,
   output logic          top,
   output logic [LW-1:0] lvl
);
   logic [N-1:0] sh;

   if (N < 2) begin : g_bad_n
      $error("store depth must be at least two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         lvl <= '0;
      end else if (push) begin
         sh  <= {sh[N-2:0], din};
         lvl <= lvl + 1'b1;
      end else if (pop) begin
         sh  <= {1'b0, sh[N-1:1]};
         lvl <= lvl - 1'b1;
      end
   end

   assign top = sh[0];
endmodule

// File: rtl/tbu_top.sv
module tbu_top #(
   parameter int ADDR_W  = 12,
   parameter int WORD_W  = 8,
   parameter int DEPTH_W = 6,
   parameter int K_MIN   = 7,
   parameter int K_NUM   = 4,
   localparam int ROW_W   = $clog2(WORD_W),
   localparam int COL_MIN = K_MIN - 1 - ROW_W,
   localparam int COL_W   = COL_MIN + K_NUM - 1,
   localparam int ITER_W  = ADDR_W - COL_MIN,
   localparam int LIFO_N  = 1 << K_NUM,
   localparam int STEP_W  = DEPTH_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         k_sel,
   input  logic [DEPTH_W-1:0] tb_depth,
   input  logic [ITER_W-1:0]  start_iter,
   input  logic [COL_W-1:0]   start_col,
   input  logic [ROW_W-1:0]   start_row,
   output logic               mem_rd,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [WORD_W-1:0]  mem_data,
   output logic               busy,
   output logic               dec_valid,
   output logic               dec_bit
);
   import tbu_pkg::*;

   if (ROW_W != 3 || WORD_W != (1 << ROW_W)) begin : g_bad_word
      $error("survivor word must be 8 bits");
   end
   if (K_NUM != 4) begin : g_bad_knum
      $error("k_sel is two bits wide");
   end

   tbu_state_e          st;
   logic [1:0]          ksel_q;
   logic [DEPTH_W-1:0]  depth_q, depth_c;
   logic [STEP_W-1:0]   step_q, last_q, last_c;
   logic [ITER_W-1:0]   iter_q;
   logic [COL_W-1:0]    col_q, col_mask, prev_col;
   logic [ROW_W-1:0]    row_q, prev_row;
   logic                v_bit, push, pop;
   logic [$clog2(LIFO_N+1)-1:0] lvl;

   // effective depth and step count for the requested length
   always_comb begin
      int n_i, lim_i, d_i;
      n_i   = LIFO_N >> k_sel;
      lim_i = (1 << DEPTH_W) + 1 - n_i;
      if (lim_i > (1 << DEPTH_W) - 2) lim_i = (1 << DEPTH_W) - 2;
      d_i = int'(tb_depth);
      if (d_i < 1) d_i = 1;
      if (d_i > lim_i) d_i = lim_i;
      depth_c  = DEPTH_W'(d_i);
      last_c   = STEP_W'(d_i + n_i - 1);
      col_mask = COL_W'((1 << (COL_MIN + int'(k_sel))) - 1);
   end

   tbu_addr #(.ADDR_W(ADDR_W), .ITER_W(ITER_W), .COL_W(COL_W),
              .COL_MIN(COL_MIN), .K_NUM(K_NUM)) u_addr (
      .ksel(ksel_q), .iter(iter_q), .col(col_q), .addr(mem_addr));

   assign v_bit = mem_data[row_q];

   tbu_prev #(.COL_W(COL_W), .COL_MIN(COL_MIN), .K_NUM(K_NUM)) u_prev (
      .ksel(ksel_q), .row_hi(row_q[2:1]), .col(col_q), .v(v_bit),
      .prev_row(prev_row), .prev_col(prev_col));

   assign push = (st == TB_EVAL) && (step_q >= {1'b0, depth_q});
   assign pop  = (st == TB_DRAIN);

   tbu_lifo #(.N(LIFO_N)) u_lifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(v_bit),
      .pop(pop), .top(dec_bit), .lvl(lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= TB_IDLE;
         ksel_q  <= '0;
         depth_q <= '0;
         step_q  <= '0;
         last_q  <= '0;
         iter_q  <= '0;
         col_q   <= '0;
         row_q   <= '0;
      end else begin
         unique case (st)
            TB_IDLE: if (start) begin
               ksel_q  <= k_sel;
               depth_q <= depth_c;
               last_q  <= last_c;
               step_q  <= STEP_W'(1);
               iter_q  <= start_iter;
               col_q   <= start_col & col_mask;
               row_q   <= start_row;
               st      <= TB_READ;
            end
            TB_READ: st <= TB_EVAL;
            TB_EVAL: begin
               row_q  <= prev_row;
               col_q  <= prev_col;
               iter_q <= iter_q - 1'b1;
               step_q <= step_q + 1'b1;
               st     <= (step_q == last_q) ? TB_DRAIN : TB_READ;
            end
            TB_DRAIN: if (lvl == 1) st <= TB_IDLE;
            default: st <= TB_IDLE;
         endcase
      end
   end

   assign mem_rd    = (st == TB_READ);
   assign busy      = (st != TB_IDLE);
   assign dec_valid = (st == TB_DRAIN);
endmodule

// File: rtl/tbu_top_chk.sv
module tbu_top_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic mem_rd,
   input logic busy,
   input logic dec_valid
);
   // R2
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   // R6
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> !mem_rd);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !dec_valid));
   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && mem_rd));
   // R6
   drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dec_valid) |-> !busy);
endmodule

bind tbu_top tbu_top_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
   .busy(busy), .dec_valid(dec_valid));

// File: tb/tbu_top_test.sv
module tbu_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  k_sel = '0;
   logic [5:0]  tb_depth = '0;
   logic [8:0]  start_iter = '0;
   logic [5:0]  start_col = '0;
   logic [2:0]  start_row = '0;
   logic        mem_rd;
   logic [11:0] mem_addr;
   logic [7:0]  mem_q = '0;
   logic        busy, dec_valid, dec_bit;

   logic [7:0] mem [4096];
   int checks = 0;
   int errors = 0;
   int exp_addr [128];
   int exp_bits [16];

   always #10 clk = ~clk;

   tbu_top uut (
      .clk(clk), .rst_n(rst_n), .start(start), .k_sel(k_sel),
      .tb_depth(tb_depth), .start_iter(start_iter), .start_col(start_col),
      .start_row(start_row), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_data(mem_q), .busy(busy), .dec_valid(dec_valid), .dec_bit(dec_bit));

   always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // builds the expected address and bit lists; returns step count via s_out, N via n_out
   task automatic model(int k, int dep, int it, int col, int row,
                        output int s_out, output int n_out, output int d_out);
      int n, lim, d, cw, hi, nx, v, a, nrow, ncol;
      n = 16 >> k;
      lim = 65 - n;
      if (lim > 62) lim = 62;
      d = dep < 1 ? 1 : dep;
      if (d > lim) d = lim;
      cw = 3 + k;
      col = col & ((1 << cw) - 1);
      for (int s = 1; s <= d + n - 1; s++) begin
         a = ((it << cw) | col) & 12'hFFF;
         exp_addr[s-1] = a;
         v = (mem[a] >> row) & 1;
         if (s >= d) exp_bits[s-d] = v;
         hi = (col >> (cw-1)) & 1;
         nx = (col >> (cw-2)) & 1;
         nrow = ((((row >> 1) & 1) ^ nx) << 2) | (v << 1) | hi;
         ncol = ((col << 1) & ((1 << cw) - 1)) | (((row >> 2) & 1) ^ hi);
         row = nrow; col = ncol;
         it = (it - 1) & 511;
      end
      s_out = d + n - 1; n_out = n; d_out = d;
   endtask

   task automatic run_case(string tag, int k, int dep, int it, int col, int row, bit poke);
      int s, n, d, rd_i, out_i, cyc, aerr, berr;
      model(k, dep, it, col, row, s, n, d);
      @(negedge clk);
      k_sel = 2'(k); tb_depth = 6'(dep); start_iter = 9'(it);
      start_col = 6'(col); start_row = 3'(row); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R1", busy, 1, {tag, " busy after start"});
      check("R1", mem_addr, exp_addr[0], {tag, " first address"});
      rd_i = 0; out_i = 0; cyc = 0; aerr = 0; berr = 0;
      while (busy && cyc < 400) begin
         if (mem_rd) begin
            if (rd_i < 128 && mem_addr != 12'(exp_addr[rd_i])) aerr++;
            if (rd_i == 1 && tag == "k7ex")
               check("R3", mem_addr, ((it - 1) & 511) << 3, "example next address");
            rd_i++;
         end
         if (dec_valid) begin
            if (out_i < n && dec_bit != exp_bits[n-1-out_i][0]) berr++;
            out_i++;
         end else cyc++;
         if (poke && cyc == 5) begin
            k_sel = 2'(3 - k); start_iter = 9'(it + 77); start = 1'b1;
         end else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      check("R2_R3_R4", aerr, 0, {tag, " address mismatches"});
      check("R5", rd_i, s, {tag, " read steps"});
      check("R5_R7", cyc, 2 * s, {tag, " busy cycles before output"});
      check("R6", out_i, n, {tag, " decoded bit count"});
      check("R6", berr, 0, {tag, " decoded bit mismatches"});
      if (poke) check("R8", aerr + berr, 0, {tag, " start ignored while busy"});
   endtask

   task automatic test_reset;
      check("R9", busy, 0, "busy after reset");
      check("R9", mem_rd, 0, "mem_rd after reset");
      check("R9", dec_valid, 0, "dec_valid after reset");
   endtask

   task automatic test_example;
      int a;
      a = (100 << 3) | 3'b100;
      mem[a] = mem[a] | 8'h20;
      run_case("k7ex", 0, 20, 100, 3'b100, 3'b101, 1'b0);
   endtask

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 73) ^ (a >> 4) ^ 8'hA5);
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_example();
      run_case("k8", 1, 30, 300, 6'h2B, 3'd6, 1'b0);
      run_case("k9", 2, 10, 17, 6'h1D, 3'd2, 1'b0);
      // R4 wrap: iteration 0 in the 6-bit field of K=10
      run_case("k10wrap", 3, 5, 0, 6'h3F, 3'd7, 1'b0);
      // R7 upper clamp and lower clamp
      run_case("k7clamp", 0, 63, 200, 6'h05, 3'd1, 1'b0);
      run_case("k10zero", 3, 0, 40, 6'h11, 3'd4, 1'b0);
      run_case("k9poke", 2, 25, 90, 6'h0C, 3'd5, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule